// File: doc/BRIEF.md
# HDLC Serial Frame Generator

This block turns a stream of bytes from a separate transmit buffer into a serial HDLC bitstream. It moves forward by exactly one bit each time the line side pulses `bit_req`. It wraps each frame in 7E flags and can append a 16-bit CRC-CCITT frame check sequence. It inserts a zero after every run of five ones in the data and the check sequence, and it sends 7F abort bytes when asked or when the buffer runs dry partway through a frame.

The buffer presents its head byte on `byte_data` with `byte_avail` high. It marks the last byte of a message with `byte_last`. The block pops that byte by raising `byte_take` during the same request that puts the byte's first bit on the line. With `share_en` set, one flag closes a frame and also opens the next. With `share_en` clear, a further flag always separates two frames.

The controller has six states:

- **IDLE**: sending a plain flag.
- **DATA**: sending a data byte.
- **FCS_LO**: sending the low byte of the check sequence.
- **FCS_HI**: sending the high byte of the check sequence.
- **CLOSE**: sending the closing flag.
- **ABORT**: sending a 7F byte.

The next state is chosen only at a byte boundary, which is the request after the last bit of a byte and after any stuffed zero that is still pending. At a boundary, an active `abort_req` always leads to ABORT. The other transitions are:

- **IDLE**: goes to DATA when a byte is available, otherwise stays in IDLE.
- **CLOSE**: goes to DATA when `share_en` is set and a byte is available, otherwise to IDLE.
- **DATA**: after the last byte, goes to FCS_LO when CRC is enabled, otherwise to CLOSE. After any other byte, it goes to DATA when a byte is available; when none is available it goes to ABORT and raises an underrun.
- **FCS_LO**: always goes to FCS_HI.
- **FCS_HI**: always goes to CLOSE.
- **ABORT**: goes to IDLE once `abort_req` is low.

Top module: `hdlc_tx_serializer`

## Requirements
- R1: After reset `ser_bit` is 1 and `underrun` is 0. With no data waiting, the block sends 7E flags back to back, least significant bit first, giving the bit sequence 0,1,1,1,1,1,1,0.
- R2: Data bytes are sent least significant bit first. `byte_take` is high only in the cycle of the `bit_req` that sends the first bit of the byte presented on `byte_data`. It rises only at a boundary after a flag or after a non-last data byte.
- R3: With `crc_en` high at the end of the last byte, two check bytes follow that byte at once. The check is the CRC-CCITT, x^16+x^12+x^5+1, processed least significant bit first (reversed constant 8408h), started at FFFFh over the frame's data bits. It is sent complemented, low byte first, each byte least significant bit first.
- R4: After five consecutive 1 bits of data or check bytes, counted across byte edges, the next request sends an extra 0. Flag and abort bytes are never stuffed and restart the count.
- R5: Every frame ends with a 7E flag. With `share_en` low, at least one further 7E precedes the next frame's first data bit. With `share_en` high, the first data bit may follow the closing flag directly.
- R6: An `abort_req` high at a boundary lets the current byte finish and then sends 7F on every boundary while the request stays high. No byte is taken during the abort. Once the request is low, 7E flags resume.
- R7: If no byte is available at the boundary after a data byte that is not marked last, `underrun` pulses for one cycle. The block then sends one 7F and, when no abort is requested, returns to flags.
- R8: `ser_bit` changes only on a clock edge where `bit_req` is high. Without a request it holds its value.
- R9: With `crc_en` low, the closing flag directly follows the last data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_req | input | 1 | Request for the next serial bit |
| byte_avail | input | 1 | Buffer holds a byte at its head |
| byte_data | input | 8 | Head byte of the buffer |
| byte_last | input | 1 | Head byte ends the message |
| byte_take | output | 1 | Pop the head byte (same cycle as `bit_req`) |
| abort_req | input | 1 | Level request to abort the frame |
| crc_en | input | 1 | Append the check sequence |
| share_en | input | 1 | Let one flag close and open frames |
| ser_bit | output | 1 | Serial line bit, updated per request |
| underrun | output | 1 | One-cycle pulse on a mid-frame empty buffer |

## Verification
The bench aims at the following corner cases and the failure each one exposes:

- **Runs of ones across byte edges and into the check bytes.** A stuffing counter that resets per byte, or that also counts flag bits, either lets six ones through or puts a stray zero in front of a flag.
- **Flag sharing against the normal double flag.** A design that mishandles this either runs two frames together or adds flags that shift every later bit.
- **Aborts raised mid-byte and held across many boundaries, plus a buffer that empties inside a frame.** A design that cuts the current byte short, or keeps popping bytes during an abort, breaks the bitstream at once.
- **Check sequences over data rich in ones.** A wrong start value, a missing complement or swapped byte order changes sixteen bits that the per-cycle comparison catches.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    parameter int BYTE_W = 8;
    parameter int FCS_W  = 16;
    parameter int ONES_RUN = 5;

    localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
    localparam logic [BYTE_W-1:0] ABORT_BYTE = 8'h7F;
    localparam logic [FCS_W-1:0]  FCS_INIT   = 16'hFFFF;
    localparam logic [FCS_W-1:0]  FCS_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA,
        S_FCS_LO,
        S_FCS_HI,
        S_CLOSE,
        S_ABORT
    } gen_state_e;

    function automatic logic is_stuffable(input gen_state_e s);
        return (s == S_DATA) || (s == S_FCS_LO) || (s == S_FCS_HI);
    endfunction

endpackage

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16 #(
    parameter int                W    = hdlc_tx_pkg::FCS_W,
    parameter logic [W-1:0]      INIT = hdlc_tx_pkg::FCS_INIT,
    parameter logic [W-1:0]      POLY = hdlc_tx_pkg::FCS_POLY_R
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic         din,
    output logic [W-1:0] crc_q
);

    logic         fb;
    logic [W-1:0] shifted;

    assign fb      = crc_q[0] ^ din;
    assign shifted = crc_q >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (clr) begin
            crc_q <= INIT;
        end else if (upd) begin
            crc_q <= fb ? (shifted ^ POLY) : shifted;
        end
    end

endmodule

// File: rtl/hdlc_stuff_ctr.sv
module hdlc_stuff_ctr #(
    parameter int RUN = hdlc_tx_pkg::ONES_RUN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic din,
    output logic stuff_due
);

    localparam int CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] RUN_V = CW'(RUN);

    logic [CW-1:0] ones_q;

    assign stuff_due = (ones_q == RUN_V);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (clr) begin
            ones_q <= '0;
        end else if (upd) begin
            ones_q <= din ? ones_q + 1'b1 : '0;
        end
    end

endmodule

// File: rtl/hdlc_byte_shifter.sv
module hdlc_byte_shifter #(
    parameter int W = hdlc_tx_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         head_bit,
    output logic         empty
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LOAD_CNT = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] left_q;

    assign head_bit = sh_q[0];
    assign empty    = (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= load_val >> 1;
            left_q <= LOAD_CNT;
        end else if (shift) begin
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
    import hdlc_tx_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_req,
    input  logic          byte_avail,
    input  logic [DW-1:0] byte_data,
    input  logic          byte_last,
    output logic          byte_take,
    input  logic          abort_req,
    input  logic          crc_en,
    input  logic          share_en,
    output logic          ser_bit,
    output logic          underrun
);

    localparam int HALF = FCS_W / 2;

    gen_state_e     st_q, st_d, st_eff;
    logic           last_q;
    logic [DW-1:0]  ld_byte;
    logic           take_c, und_c;
    logic           stuff_due, sh_empty, sh_bit;
    logic           stuff_now, boundary, shift_now, emit;
    logic [FCS_W-1:0] crc_q;
    logic           crc_clr, crc_upd, ones_clr, ones_upd;

    assign stuff_now = bit_req && stuff_due;
    assign boundary  = bit_req && !stuff_due && sh_empty;
    assign shift_now = bit_req && !stuff_due && !sh_empty;

    // next state and byte, evaluated for a boundary
    always_comb begin
        st_d    = st_q;
        ld_byte = FLAG_BYTE;
        take_c  = 1'b0;
        und_c   = 1'b0;
        if (abort_req) begin
            st_d    = S_ABORT;
            ld_byte = ABORT_BYTE;
        end else begin
            unique case (st_q)
                S_IDLE, S_CLOSE: begin
                    if (byte_avail && (st_q == S_IDLE || share_en)) begin
                        st_d    = S_DATA;
                        ld_byte = byte_data;
                        take_c  = 1'b1;
                    end else begin
                        st_d    = S_IDLE;
                        ld_byte = FLAG_BYTE;
                    end
                end
                S_DATA: begin
                    if (last_q) begin
                        if (crc_en) begin
                            st_d    = S_FCS_LO;
                            ld_byte = ~crc_q[HALF-1:0];
                        end else begin
                            st_d    = S_CLOSE;
                            ld_byte = FLAG_BYTE;
                        end
                    end else if (byte_avail) begin
                        st_d    = S_DATA;
                        ld_byte = byte_data;
                        take_c  = 1'b1;
                    end else begin
                        st_d    = S_ABORT;
                        ld_byte = ABORT_BYTE;
                        und_c   = 1'b1;
                    end
                end
                S_FCS_LO: begin
                    st_d    = S_FCS_HI;
                    ld_byte = ~crc_q[FCS_W-1:HALF];
                end
                S_FCS_HI: begin
                    st_d    = S_CLOSE;
                    ld_byte = FLAG_BYTE;
                end
                S_ABORT: begin
                    st_d    = S_IDLE;
                    ld_byte = FLAG_BYTE;
                end
                default: begin
                    st_d    = S_IDLE;
                    ld_byte = FLAG_BYTE;
                end
            endcase
        end
    end

    assign st_eff    = boundary ? st_d : st_q;
    assign byte_take = boundary && take_c;
    assign emit      = stuff_now ? 1'b0 : (boundary ? ld_byte[0] : sh_bit);

    assign ones_clr = stuff_now || (boundary && !is_stuffable(st_d));
    assign ones_upd = (boundary || shift_now) && is_stuffable(st_eff);
    assign crc_clr  = boundary && !is_stuffable(st_d);
    assign crc_upd  = (boundary || shift_now) && (st_eff == S_DATA);

    hdlc_byte_shifter #(.W(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (boundary),
        .load_val (ld_byte),
        .shift    (shift_now),
        .head_bit (sh_bit),
        .empty    (sh_empty)
    );

    hdlc_stuff_ctr #(.RUN(ONES_RUN)) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ones_clr),
        .upd       (ones_upd),
        .din       (emit),
        .stuff_due (stuff_due)
    );

    hdlc_fcs16 #(.W(FCS_W), .INIT(FCS_INIT), .POLY(FCS_POLY_R)) u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (crc_upd),
        .din   (emit),
        .crc_q (crc_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            last_q <= 1'b0;
        end else if (boundary) begin
            st_q <= st_d;
            if (take_c) begin
                last_q <= byte_last;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_bit  <= 1'b1;
            underrun <= 1'b0;
        end else begin
            underrun <= boundary && und_c;
            if (bit_req) begin
                ser_bit <= emit;
            end
        end
    end

endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_req,
    input logic byte_avail,
    input logic byte_take,
    input logic abort_req,
    input logic ser_bit,
    input logic underrun
);

    AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> (bit_req && byte_avail)); // R2

    AST_NO_TAKE_IN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> !abort_req); // R6

    AST_HOLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_req |=> $stable(ser_bit)); // R8

    AST_UNDERRUN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!$past(byte_avail) && $past(bit_req))); // R7

    AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun); // R7

endmodule

bind hdlc_tx_serializer hdlc_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_req    (bit_req),
    .byte_avail (byte_avail),
    .byte_take  (byte_take),
    .abort_req  (abort_req),
    .ser_bit    (ser_bit),
    .underrun   (underrun)
);

// File: tb/hdlc_tx_serializer_bench.sv
module hdlc_tx_serializer_bench;

    localparam int M_IDLE = 0, M_DATA = 1, M_FCSL = 2, M_FCSH = 3, M_CLOSE = 4, M_ABORT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_req = 1'b0;
    logic       abort_req = 1'b0;
    logic       crc_en = 1'b0;
    logic       share_en = 1'b0;
    logic       byte_take, ser_bit, underrun;
    logic [8:0] buf_q[$];
    logic       byte_avail;
    logic [7:0] byte_data;
    logic       byte_last;

    int vectors = 0;
    int fails = 0;

    // reference model state
    int   m_st = M_IDLE;
    int   m_ones = 0;
    int   m_crc = 'hFFFF;
    bit   m_last = 0;
    bit   m_stf = 0;
    bit   m_bits[$];
    bit   exp_bit = 1;
    bit   exp_und = 0;
    bit   exp_take = 0;
    bit   do_pop = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    assign byte_avail = (buf_q.size() > 0);
    assign byte_data  = byte_avail ? buf_q[0][7:0] : 8'h00;
    assign byte_last  = byte_avail ? buf_q[0][8] : 1'b0;

    hdlc_tx_serializer u_hdlc_tx_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_req    (bit_req),
        .byte_avail (byte_avail),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .byte_take  (byte_take),
        .abort_req  (abort_req),
        .crc_en     (crc_en),
        .share_en   (share_en),
        .ser_bit    (ser_bit),
        .underrun   (underrun)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit req);
        int         nxt;
        logic [7:0] b;
        bit         b0;
        exp_und  = 0;
        exp_take = 0;
        do_pop   = 0;
        if (!req) begin
            tag = "R8";
            return;
        end
        if (m_ones == 5) begin
            exp_bit = 0;
            m_ones  = 0;
            tag     = "R4";
            return;
        end
        if (m_bits.size() == 0) begin
            nxt = m_st;
            b   = 8'h7E;
            if (abort_req) nxt = M_ABORT;
            else case (m_st)
                M_ABORT: nxt = M_IDLE;
                M_IDLE:  nxt = (buf_q.size() > 0) ? M_DATA : M_IDLE;
                M_CLOSE: nxt = (share_en && buf_q.size() > 0) ? M_DATA : M_IDLE;
                M_DATA: begin
                    if (m_last) nxt = crc_en ? M_FCSL : M_CLOSE;
                    else if (buf_q.size() > 0) nxt = M_DATA;
                    else begin nxt = M_ABORT; exp_und = 1; end
                end
                M_FCSL: nxt = M_FCSH;
                default: nxt = M_CLOSE;
            endcase
            case (nxt)
                M_IDLE:  begin b = 8'h7E; tag = (m_st == M_CLOSE) ? "R5" : "R1"; end
                M_DATA:  begin b = buf_q[0][7:0]; m_last = buf_q[0][8]; exp_take = 1; do_pop = 1; tag = "R2"; end
                M_FCSL:  begin b = ~m_crc[7:0]; tag = "R3"; end
                M_FCSH:  begin b = ~m_crc[15:8]; tag = "R3"; end
                M_CLOSE: begin b = 8'h7E; tag = (m_st == M_DATA) ? "R9" : "R5"; end
                default: begin b = 8'h7F; tag = exp_und ? "R7" : "R6"; end
            endcase
            if (nxt == M_IDLE || nxt == M_CLOSE || nxt == M_ABORT) m_crc = 'hFFFF;
            for (int i = 0; i < 8; i++) m_bits.push_back(b[i]);
            m_stf = (nxt == M_DATA || nxt == M_FCSL || nxt == M_FCSH);
            if (!m_stf) m_ones = 0;
            m_st = nxt;
        end
        b0 = m_bits.pop_front();
        exp_bit = b0;
        if (m_stf) m_ones = b0 ? m_ones + 1 : 0;
        if (m_st == M_DATA) begin
            if ((m_crc[0] ^ b0) != 0) m_crc = (m_crc >> 1) ^ 'h8408;
            else m_crc = m_crc >> 1;
        end
    endtask

    task automatic step(input bit req);
        @(negedge clk);
        check(tag, "ser_bit", ser_bit, exp_bit);
        check(exp_und ? "R7" : tag, "underrun", underrun, exp_und);
        bit_req = req;
        #1;
        model_step(req);
        check("R2", "byte_take", byte_take, exp_take);
        @(posedge clk);
        #1;
        if (do_pop) void'(buf_q.pop_front());
    endtask

    task automatic run(input int n, input int density);
        for (int i = 0; i < n; i++) step(($urandom % 100) < density);
    endtask

    task automatic push_frame(input int len, input bit with_last, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = (i % 3 == 0) ? 8'hFF : (seed ^ 8'(i * 37));
            buf_q.push_back({with_last && (i == len - 1), v});
        end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset ser_bit", ser_bit, 1);
        check("R1", "reset underrun", underrun, 0);
        check("R1", "reset byte_take", byte_take, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        run(40, 100);                           // R1 idle flags
        crc_en = 1; share_en = 0;
        buf_q.push_back({1'b0, 8'hFF});
        buf_q.push_back({1'b0, 8'h3E});
        buf_q.push_back({1'b0, 8'h7E});
        buf_q.push_back({1'b1, 8'hF8});
        run(120, 100);                          // R2 R3 R4 R5
        share_en = 1;
        push_frame(4, 1, 8'h5A);
        push_frame(3, 1, 8'hC3);
        run(220, 70);                           // R5 shared flag
        crc_en = 0; share_en = 0;
        push_frame(3, 1, 8'h11);
        push_frame(2, 1, 8'h80);
        run(160, 100);                          // R9
        crc_en = 1;
        push_frame(3, 0, 8'h22);
        run(80, 100);                           // R7 underrun
        push_frame(10, 1, 8'h9C);
        run(30, 100);
        abort_req = 1;                          // R6
        run(45, 90);
        abort_req = 0;
        run(200, 100);
        for (int k = 0; k < 25; k++) begin
            crc_en   = ($urandom % 4) != 0;
            share_en = $urandom % 2;
            push_frame(1 + $urandom % 6, ($urandom % 5) != 0, 8'($urandom));
            run(40 + $urandom % 60, 40 + $urandom % 61);
            if (($urandom % 4) == 0) begin
                abort_req = 1;
                run(5 + $urandom % 20, 100);
                abort_req = 0;
            end
            run(60, 100);
        end
        buf_q.delete();
        run(120, 100);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule